// File: doc/BRIEF.md
# Distributed-Arithmetic 8-Point DCT

This block computes the eight coefficients of a one-dimensional DCT-II over a block of eight signed 16-bit samples without any multiplier. Samples arrive one per clock over a valid/ready handshake. Once eight have been taken, a single shared adder/subtractor folds the buffer into four symmetric sums and four symmetric differences, one mirror pair per cycle. Eight accumulation lanes then walk the 17 bit planes of those operands, most significant plane first. In each plane, every lane looks up a 16-entry table of precomputed coefficient sums and folds the result into a doubling accumulator. The coefficients then leave on eight consecutive cycles, each tagged with its index.

The block is meant to sit in the row or column pass of an image or video transform pipeline. A synchronous clear discards any block in progress and returns the engine to loading. Coefficient tables are computed at elaboration from integer cosine constants, so the table precision follows a parameter.

Top module: `da_dct8`

## Requirements
- R1: While rst_n is low at a rising edge, or clr is high at a rising edge, the block returns to loading with no samples held. In the next cycle in_ready is 1 and coef_valid is 0, and any block in progress is discarded.
- R2: A sample is taken at each rising edge where in_valid and in_ready are both 1. Samples are numbered 0 to 7 in arrival order, and idle cycles between them are allowed. in_ready is 1 only while loading and falls in the cycle after the eighth sample is taken.
- R3: Operand pairs are sample i and sample 7-i. The even coefficients (0, 2, 4, 6) depend only on the four 17-bit sums, and the odd coefficients only on the four 17-bit differences. An input with x[i] = x[7-i] gives odd coefficients of 0, and an input with x[i] = -x[7-i] gives even coefficients of 0, within the R7 tolerance.
- R4: coef_valid is high for exactly 8 consecutive cycles. The first of these follows the 21st rising edge after the edge that takes the eighth sample (4 butterfly edges and then 17 plane edges). coef_idx runs 0,1,...,7 over these cycles, and in_ready is 1 in the cycle after index 7. A block therefore takes 37 cycles in all.
- R5: Each table address is 4 bits wide and is built from one bit position of the four operands. Operand 0 (the pair 0/7) supplies address bit 3 and operand 3 (the pair 3/4) supplies bit 0. Each entry is round(2^14 x the sum of that row's coefficients whose address bit is 1).
- R6: Bit planes are taken from bit 16 down to bit 0. The table value of plane 16 is subtracted, and the values of all other planes are added, with the total doubled between planes. Negative samples therefore give correctly signed coefficients.
- R7: coef_data is the low 16 bits of floor(acc / 2^15). For any block whose exact coefficients lie within +-32767, it stays within 3 LSB of 0.5*c(k)*sum x[i]*cos((2i+1)k*pi/16), where c(0)=1/sqrt(2) and c(k)=1 otherwise. The accumulator never overflows.
- R8: in_valid asserted while in_ready is 0 has no effect on the coefficient values or on the timing of the current block or the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear, abandons the current block |
| in_valid | input | 1 | in_data carries a sample |
| in_ready | output | 1 | Block is loading and takes a sample this cycle |
| in_data | input | 16 | Signed two's-complement sample |
| coef_valid | output | 1 | coef_data and coef_idx carry a coefficient |
| coef_idx | output | 3 | Frequency index of the coefficient |
| coef_data | output | 16 | Signed coefficient |

## Verification
A reference model in the bench computes the transform from its cosine definition and follows the handshake cycle by cycle. Stimulus includes a unit impulse at each of the eight positions, which separates errors in the address bit order and in the pair selection. DC and ramp blocks exercise mainly the even and odd paths respectively. Symmetric and antisymmetric blocks must each silence one half of the outputs, which exposes any mix-up between sums and differences. All-negative and alternating-sign blocks, and bounded random blocks, exercise the subtracted sign plane. Gaps in in_valid, in_valid held high while busy, and clears issued during loading and during computation check the sequencing and the discard behaviour.

// File: rtl/da_dct8_pkg.sv
// Package da_dct8_pkg
// Shared state type and the elaboration-time coefficient-table builder for
// the distributed-arithmetic DCT. Assumes 0 < table fraction bits < 20.
package da_dct8_pkg;

    // Cosine constants scaled by 2^20 (rounded), the reference precision
    localparam int REF_FRAC = 20;
    localparam int K_A = 741455;   // cos(pi/4)
    localparam int K_B = 968758;   // cos(pi/8)
    localparam int K_C = 401273;   // sin(pi/8)
    localparam int K_D = 1028428;  // cos(pi/16)
    localparam int K_E = 871859;   // cos(3pi/16)
    localparam int K_F = 582558;   // sin(3pi/16)
    localparam int K_G = 204567;   // sin(pi/16)

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_BFLY = 2'd1,
        ST_CALC = 2'd2,
        ST_OUT  = 2'd3
    } dct_state_e;

    // Coefficient of operand col (0..3) for output row k (0..7), scale 2^20
    function automatic int row_coef(input int k, input int col);
        int r [4];
        case (k)
            0:       r = '{ K_A,  K_A,  K_A,  K_A};
            2:       r = '{ K_B,  K_C, -K_C, -K_B};
            4:       r = '{ K_A, -K_A, -K_A,  K_A};
            6:       r = '{ K_C, -K_B,  K_B, -K_C};
            1:       r = '{ K_D,  K_E,  K_F,  K_G};
            3:       r = '{ K_E, -K_G, -K_D, -K_F};
            5:       r = '{ K_F, -K_D,  K_G,  K_E};
            default: r = '{ K_G, -K_F,  K_E, -K_D};
        endcase
        return r[col];
    endfunction

    // Table entry: sum of selected coefficients, rounded to 'frac' bits.
    // Address bit 3 selects operand 0, bit 0 selects operand 3.
    function automatic int table_entry(input int k, input int addr, input int frac);
        int acc;
        int sh;
        acc = 0;
        for (int m = 0; m < 4; m++) begin
            if (((addr >> (3 - m)) & 1) == 1) acc += row_coef(k, m);
        end
        sh = REF_FRAC - frac;
        return (acc + (1 << (sh - 1))) >>> sh;
    endfunction

endpackage

// File: rtl/da_dct8_loader.sv
// Module da_dct8_loader
// Holds the eight incoming samples and folds them into four mirror sums and
// four mirror differences, one pair (i, 7-i) per butterfly cycle, using one
// shared adder and subtractor. Assumes OPW = DW + 1 so that no result overflows.
module da_dct8_loader #(
    parameter int DW  = 16,
    parameter int OPW = DW + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [2:0]            wr_idx,
    input  logic [DW-1:0]         wr_data,
    input  logic                  bf_en,
    input  logic [1:0]            bf_idx,
    output logic signed [OPW-1:0] sum_o [4],
    output logic signed [OPW-1:0] dif_o [4]
);

    logic signed [DW-1:0]  smp [8];
    logic [2:0]            mir_idx;
    logic signed [OPW-1:0] lo_ext;
    logic signed [OPW-1:0] hi_ext;

    // Mirror read: pair member i and its partner 7-i
    assign mir_idx = 3'd7 - {1'b0, bf_idx};
    assign lo_ext  = OPW'(smp[{1'b0, bf_idx}]);
    assign hi_ext  = OPW'(smp[mir_idx]);

    // Sample store, written in arrival order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) smp[i] <= '0;
        end else if (wr_en) begin
            smp[wr_idx] <= $signed(wr_data);
        end
    end

    // Butterfly registers, one pair updated per butterfly cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                sum_o[i] <= '0;
                dif_o[i] <= '0;
            end
        end else if (bf_en) begin
            sum_o[bf_idx] <= lo_ext + hi_ext;
            dif_o[bf_idx] <= lo_ext - hi_ext;
        end
    end

endmodule

// File: rtl/da_dct8_bitaddr.sv
// Module da_dct8_bitaddr
// Builds a 4-bit table address from one bit plane of four operands, with
// operand 0 in the address MSB. Purely combinational; assumes bp < OPW.
module da_dct8_bitaddr #(
    parameter int OPW = 17,
    parameter int BPW = $clog2(OPW)
) (
    input  logic signed [OPW-1:0] op [4],
    input  logic [BPW-1:0]        bp,
    output logic [3:0]            addr
);

    // One address bit per operand
    for (genvar m = 0; m < 4; m++) begin : g_bit
        assign addr[3-m] = op[m][bp];
    end

endmodule

// File: rtl/da_dct8_lane.sv
// Module da_dct8_lane
// One output coefficient: a 16-entry coefficient-sum table for row ROW and
// a doubling accumulator. The first plane loads the negated table value
// (sign plane), later planes double and add. Assumes planes arrive MSB first.
module da_dct8_lane #(
    parameter int ROW  = 0,
    parameter int FRAC = 14,
    parameter int RW   = FRAC + 4,
    parameter int AW   = RW + 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 step,
    input  logic                 first,
    input  logic [3:0]           addr,
    output logic signed [AW-1:0] acc_o
);

    logic signed [RW-1:0] tbl [16];
    logic signed [RW-1:0] tbl_q;
    logic signed [AW-1:0] tbl_ext;

    // Coefficient-sum table, computed at elaboration
    for (genvar a = 0; a < 16; a++) begin : g_tbl
        assign tbl[a] = RW'(da_dct8_pkg::table_entry(ROW, a, FRAC));
    end

    // Table lookup, sign-extended to accumulator width
    assign tbl_q   = tbl[addr];
    assign tbl_ext = AW'(tbl_q);

    // Shift-accumulate across bit planes
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_o <= '0;
        end else if (step) begin
            if (first) acc_o <= -tbl_ext;
            else       acc_o <= (acc_o <<< 1) + tbl_ext;
        end
    end

    // Doubling must never lose a significant bit
    assert_acc_headroom_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !first && !clr) |-> (acc_o[AW-1] == acc_o[AW-2]));

endmodule

// File: rtl/da_dct8.sv
// Module da_dct8
// Top of the distributed-arithmetic 8-point DCT-II. Sequencer runs
// load (8 samples) -> butterfly (4 cycles) -> bit planes (OPW cycles)
// -> output (8 cycles). Assumes inputs are signed DW-bit samples.
module da_dct8 #(
    parameter int DW   = 16,
    parameter int OW   = 16,
    parameter int FRAC = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          coef_valid,
    output logic [2:0]    coef_idx,
    output logic [OW-1:0] coef_data
);
    import da_dct8_pkg::*;

    localparam int OPW       = DW + 1;
    localparam int BPW       = $clog2(OPW);
    localparam int RW        = FRAC + 4;
    localparam int AW        = RW + OPW + 1;
    localparam int OUT_SHIFT = FRAC + 1;
    localparam logic [BPW-1:0] BP_TOP = BPW'(OPW - 1);

    dct_state_e           state;
    logic [2:0]           cnt;
    logic [BPW-1:0]       bp;
    logic signed [OPW-1:0] sums [4];
    logic signed [OPW-1:0] difs [4];
    logic [3:0]           even_addr;
    logic [3:0]           odd_addr;
    logic signed [AW-1:0] lane_acc [8];
    logic                 take;
    logic                 calc_step;
    logic                 first_plane;

    assign in_ready    = (state == ST_LOAD);
    assign take        = in_valid && in_ready;
    assign calc_step   = (state == ST_CALC);
    assign first_plane = (bp == BP_TOP);
    assign coef_valid  = (state == ST_OUT);
    assign coef_idx    = cnt;
    assign coef_data   = OW'(lane_acc[cnt] >>> OUT_SHIFT);

    // Sequencer: phase, shared slot counter and bit-plane pointer
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state <= ST_LOAD;
            cnt   <= '0;
            bp    <= BP_TOP;
        end else begin
            case (state)
                ST_LOAD: if (in_valid) begin
                    cnt <= cnt + 3'd1;
                    if (cnt == 3'd7) state <= ST_BFLY;
                end
                ST_BFLY: begin
                    cnt <= cnt + 3'd1;
                    if (cnt == 3'd3) begin
                        cnt   <= '0;
                        bp    <= BP_TOP;
                        state <= ST_CALC;
                    end
                end
                ST_CALC: begin
                    bp <= bp - 1'b1;
                    if (bp == '0) begin
                        bp    <= BP_TOP;
                        state <= ST_OUT;
                    end
                end
                default: begin
                    cnt <= cnt + 3'd1;
                    if (cnt == 3'd7) state <= ST_LOAD;
                end
            endcase
        end
    end

    da_dct8_loader #(.DW(DW), .OPW(OPW)) u_loader (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (take),
        .wr_idx  (cnt),
        .wr_data (in_data),
        .bf_en   (state == ST_BFLY),
        .bf_idx  (cnt[1:0]),
        .sum_o   (sums),
        .dif_o   (difs)
    );

    da_dct8_bitaddr #(.OPW(OPW), .BPW(BPW)) u_addr_even (
        .op   (sums),
        .bp   (bp),
        .addr (even_addr)
    );

    da_dct8_bitaddr #(.OPW(OPW), .BPW(BPW)) u_addr_odd (
        .op   (difs),
        .bp   (bp),
        .addr (odd_addr)
    );

    // Eight lanes: even rows read sum planes, odd rows read difference planes
    for (genvar k = 0; k < 8; k++) begin : g_lane
        da_dct8_lane #(.ROW(k), .FRAC(FRAC), .RW(RW), .AW(AW)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .step  (calc_step),
            .first (first_plane),
            .addr  (((k % 2) == 0) ? even_addr : odd_addr),
            .acc_o (lane_acc[k])
        );
    end

    // Clear always lands in loading with no output
    assert_clear_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (in_ready && !coef_valid));

    // Loading and output never overlap
    assert_ready_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !coef_valid);

    // The eighth accepted sample closes the load window
    assert_fill_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cnt == 3'd7 && !clr) |=> !in_ready);

    // Indices advance by one on consecutive output cycles
    assert_idx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_valid && coef_idx != 3'd7 && !clr) |=>
            (coef_valid && coef_idx == $past(coef_idx) + 3'd1));

    // After the last index the block is ready again
    assert_resume_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_valid && coef_idx == 3'd7 && !clr) |=> in_ready);

    // Planes are visited strictly downward
    assert_plane_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CALC && bp != '0 && !clr) |=> (bp == $past(bp) - 1'b1));

endmodule

// File: tb/da_dct8_tb.sv
// Bench for da_dct8: a behavioural model of the handshake and of the
// DCT-II definition, compared against the outputs on every falling edge.
module da_dct8_tb;

    localparam int DW = 16;
    localparam int OW = 16;
    localparam real TOL = 3.0;
    localparam real PI  = 3.14159265358979323846;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          coef_valid;
    logic [2:0]    coef_idx;
    logic [OW-1:0] coef_data;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string tag = "R7";

    // Model state: 0 = loading, 1 = busy, 2 = output
    int  m_mode = 0;
    int  m_cnt = 0;
    int  m_samp [8];
    real exp_x [8];

    always #2 clk = ~clk;

    da_dct8 u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .coef_valid (coef_valid),
        .coef_idx   (coef_idx),
        .coef_data  (coef_data)
    );

    task automatic fail(input string req, input string what, input int act, input int exp);
        failures++;
        $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    endtask

    // Reference transform straight from the cosine definition
    task automatic compute_ref();
        for (int k = 0; k < 8; k++) begin
            real s;
            s = 0.0;
            for (int i = 0; i < 8; i++)
                s += m_samp[i] * $cos((2.0 * i + 1.0) * k * PI / 16.0);
            exp_x[k] = 0.5 * s * ((k == 0) ? (1.0 / $sqrt(2.0)) : 1.0);
        end
    endtask

    // Cycle model of the handshake (R1 R2 R4 R8)
    always @(posedge clk) begin
        if (!rst_n || clr) begin
            m_mode = 0;
            m_cnt  = 0;
        end else begin
            case (m_mode)
                0: if (in_valid) begin
                    m_samp[m_cnt] = int'($signed(in_data));
                    m_cnt++;
                    if (m_cnt == 8) begin
                        compute_ref();
                        m_mode = 1;
                        m_cnt  = 0;
                    end
                end
                1: begin
                    m_cnt++;
                    if (m_cnt == 21) begin m_mode = 2; m_cnt = 0; end
                end
                default: begin
                    m_cnt++;
                    if (m_cnt == 8) begin m_mode = 0; m_cnt = 0; end
                end
            endcase
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (in_ready !== (m_mode == 0))
                fail("R2", "in_ready", int'(in_ready), int'(m_mode == 0));
            checks++;
            if (coef_valid !== (m_mode == 2))
                fail("R4", "coef_valid", int'(coef_valid), int'(m_mode == 2));
            if (m_mode == 2 && coef_valid === 1'b1) begin
                int  act;
                real d;
                checks++;
                if (coef_idx !== 3'(m_cnt))
                    fail("R4", "coef_idx", int'(coef_idx), m_cnt);
                act = int'($signed(coef_data));
                d = act - exp_x[m_cnt];
                checks++;
                if (d > TOL || d < -TOL)
                    fail({"R7/", tag}, $sformatf("coef[%0d]", m_cnt), act, $rtoi(exp_x[m_cnt]));
            end
        end
    end

    // Load one block, optional idle gap and optional in_valid while busy (R8)
    task automatic send(input int xs [8], input bit gap, input bit junk);
        for (int i = 0; i < 8; i++) begin
            if (gap && i == 3) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_data  = 16'h1234;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = xs[i][DW-1:0];
        end
        @(negedge clk);
        in_valid = junk;
        in_data  = 16'h7abc;
        repeat (20) @(negedge clk);
        in_valid = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL R4 watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int xs [8];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (!(in_ready === 1'b1 && coef_valid === 1'b0))
            fail("R1", "reset state", int'({in_ready, coef_valid}), 2);

        // R5: impulse at each position checks address bit order and pairing
        tag = "R5";
        for (int p = 0; p < 8; p++) begin
            for (int i = 0; i < 8; i++) xs[i] = (i == p) ? 9000 : 0;
            send(xs, 1'b0, 1'b0);
        end

        // R7: DC and ramp
        tag = "R7";
        xs = '{5000, 5000, 5000, 5000, 5000, 5000, 5000, 5000};
        send(xs, 1'b0, 1'b0);
        xs = '{-7000, -5000, -3000, -1000, 1000, 3000, 5000, 7000};
        send(xs, 1'b0, 1'b0);

        // R3: symmetric silences odd outputs, antisymmetric silences even
        tag = "R3";
        xs = '{1200, -3400, 5600, 7800, 7800, 5600, -3400, 1200};
        send(xs, 1'b0, 1'b0);
        xs = '{10000, -2500, 4100, -900, 900, -4100, 2500, -10000};
        send(xs, 1'b0, 1'b0);

        // R6: negative values and alternating sign exercise the sign plane
        tag = "R6";
        xs = '{-11000, -11000, -11000, -11000, -11000, -11000, -11000, -11000};
        send(xs, 1'b0, 1'b0);
        xs = '{11000, -11000, 11000, -11000, 11000, -11000, 11000, -11000};
        send(xs, 1'b0, 1'b0);
        xs = '{-1, -1, -1, -1, -1, -1, -1, -1};
        send(xs, 1'b0, 1'b0);

        // R2: idle gap during loading
        tag = "R2";
        xs = '{300, -200, 100, 0, 4000, -4000, 2000, 1};
        send(xs, 1'b1, 1'b0);

        // R8: in_valid held while busy must not disturb this block or the next
        tag = "R8";
        xs = '{8000, 7000, -6000, 5000, -4000, 3000, -2000, 1000};
        send(xs, 1'b0, 1'b1);
        xs = '{-100, 200, -300, 400, -500, 600, -700, 800};
        send(xs, 1'b0, 1'b0);

        // R1: clear during loading discards the partial block
        tag = "R1";
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 16'h5555;
        end
        @(negedge clk);
        in_valid = 1'b0;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        checks++;
        if (!(in_ready === 1'b1 && coef_valid === 1'b0))
            fail("R1", "clear in load", int'({in_ready, coef_valid}), 2);
        xs = '{2000, 2100, 2200, 2300, 2400, 2500, 2600, 2700};
        send(xs, 1'b0, 1'b0);

        // R1: clear during bit-plane computation
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 16'h0f00;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (10) @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        checks++;
        if (!(in_ready === 1'b1 && coef_valid === 1'b0))
            fail("R1", "clear in calc", int'({in_ready, coef_valid}), 2);
        xs = '{-3000, 6000, -9000, 3000, 0, 1500, -1500, 4500};
        send(xs, 1'b0, 1'b0);

        // R7: bounded random blocks
        tag = "R7";
        for (int b = 0; b < 12; b++) begin
            for (int i = 0; i < 8; i++) xs[i] = int'($urandom % 22001) - 11000;
            send(xs, 1'b0, 1'b0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule